// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block produces, one clock cycle at a time, the control signals for a multicycle datapath that runs load word, store word, register-to-register ALU operations, branch-if-equal and jump. The control comes from a small microprogram held in an internal read-only store, not from a hand-written next-state function. A micro-program counter selects the current microword. The microword's fields are then expanded into individual datapath strobes and selects. A 2-bit sequencing field in each word picks the next micro-address. It can step to the following word, go back to the fetch word, or jump through one of two opcode-indexed dispatch tables.

The only functional input is the 6-bit opcode of the instruction held in the datapath's instruction register. The outputs are the datapath controls and the current micro-address, which is exported so the microprogram's progress can be observed. A load takes five microwords. Store and ALU operations take four. Branch and jump take three. An opcode that neither dispatch table knows sends the sequencer back to fetch.

Top module: `ucode_seq_ctrl`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is active, `upc` is 0, the fetch address. After release, the first microword executed is fetch.
- R2: Word 0 (fetch) performs these actions:
  - memory read at the PC (`mem_rd`=1, `addr_sel`=0) and `ir_wr`=1;
  - ALU add of PC and 4 (`alu_op`=00, `alu_a_sel`=0, `alu_b_sel`=01);
  - PC write from the ALU (`pc_wr`=1, `pc_src`=00).

  The next address is 1.
- R3: Word 1 (decode) performs an add of PC and the shifted immediate (`alu_op`=00, `alu_a_sel`=0, `alu_b_sel`=11) with no write strobe. It dispatches on the opcode sampled at the clock edge:
  - 0x00 goes to 6;
  - 0x23 and 0x2B go to 2;
  - 0x04 goes to 8;
  - 0x02 goes to 9;
  - any other opcode goes to 0.
- R4: Word 2 (address computation) adds register A and the sign-extended immediate (`alu_op`=00, `alu_a_sel`=1, `alu_b_sel`=10). It then dispatches through the second table: 0x23 goes to 3, 0x2B goes to 5, and any other opcode goes to 0.
- R5: Word 3 reads memory at ALUOut (`mem_rd`=1, `addr_sel`=1, `ir_wr`=0) and steps to 4. Word 4 writes the memory data register into the rt register (`reg_wr`=1, `reg_dst_sel`=0, `wb_sel`=1) and returns to 0.
- R6: Word 5 writes memory at ALUOut (`mem_wr`=1, `addr_sel`=1) and returns to 0.
- R7: Word 6 runs the funct-coded ALU operation on A and B (`alu_op`=10, `alu_a_sel`=1, `alu_b_sel`=00) and steps to 7. Word 7 writes ALUOut to the rd register (`reg_wr`=1, `reg_dst_sel`=1, `wb_sel`=0) and returns to 0.
- R8: Word 8 subtracts B from A (`alu_op`=01, `alu_a_sel`=1, `alu_b_sel`=00) with the zero-conditional PC write (`pc_wr_cond`=1, `pc_src`=01) and returns to 0.
- R9: Word 9 writes the jump target into the PC (`pc_wr`=1, `pc_src`=10) and returns to 0.
- R10: Every control not named for the current word is 0. `mem_rd` and `mem_wr` are never both 1, and `pc_wr` and `pc_wr_cond` are never both 1.
- R11: `upc` changes on every rising clock edge. A stepping word moves to `upc`+1 and a returning word moves to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU zero flag is set |
| addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALUOut |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst_sel | output | 1 | Destination: 0 = rt, 1 = rd |
| wb_sel | output | 1 | Write data: 0 = ALUOut, 1 = memory data register |
| alu_op | output | 2 | 00 add, 01 subtract, 10 use funct field |
| alu_a_sel | output | 1 | ALU first operand: 0 = PC, 1 = A |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target |
| upc | output | 4 | Current micro-address |

## Verification
Some properties are checked on every cycle:
- exclusive memory strobes and exclusive PC write strobes;
- the instruction register loads only during a PC-addressed read;
- a stepping word advances `upc` by one and a returning word lands on fetch;
- `upc` never leaves the populated part of the store;
- a decode-time jump or ALU opcode reaches its dispatch target.

Other behaviour is visible only in the bench's scenarios:
- the exact microword order of each instruction class;
- the full control bundle per word;
- second-table dispatch when the opcode is altered after decode;
- unknown opcodes falling back to fetch;
- an asynchronous reset in the middle of a load.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

   typedef enum logic [1:0] {
      SEQ_FETCH = 2'b00,
      SEQ_DISP1 = 2'b01,
      SEQ_DISP2 = 2'b10,
      SEQ_NEXT  = 2'b11
   } seq_e;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'b00,
      ALU_SUB  = 2'b01,
      ALU_FUNC = 2'b10
   } alu_e;

   typedef enum logic [1:0] {
      SRCB_REG    = 2'b00,
      SRCB_FOUR   = 2'b01,
      SRCB_IMM    = 2'b10,
      SRCB_IMM_SH = 2'b11
   } srcb_e;

   typedef enum logic [1:0] {
      RCTL_NONE   = 2'b00,
      RCTL_READ   = 2'b01,
      RCTL_WR_ALU = 2'b10,
      RCTL_WR_MDR = 2'b11
   } rctl_e;

   typedef enum logic [1:0] {
      MCTL_NONE   = 2'b00,
      MCTL_IFETCH = 2'b01,
      MCTL_RD_ALU = 2'b10,
      MCTL_WR_ALU = 2'b11
   } mctl_e;

   typedef enum logic [1:0] {
      PCW_NONE = 2'b00,
      PCW_ALU  = 2'b01,
      PCW_COND = 2'b10,
      PCW_JUMP = 2'b11
   } pcw_e;

   typedef struct packed {
      alu_e  alu;
      logic  src_a;
      srcb_e src_b;
      rctl_e rctl;
      mctl_e mctl;
      pcw_e  pctl;
      seq_e  seq;
   } uword_t;

   localparam int UA_FETCH  = 0;
   localparam int UA_DECODE = 1;
   localparam int UA_MEM1   = 2;
   localparam int UA_LD2    = 3;
   localparam int UA_LD3    = 4;
   localparam int UA_ST2    = 5;
   localparam int UA_ALU1   = 6;
   localparam int UA_ALU2   = 7;
   localparam int UA_BR1    = 8;
   localparam int UA_JMP1   = 9;
   localparam int UA_LAST   = UA_JMP1;

endpackage

// File: rtl/ucs_dispatch.sv
module ucs_dispatch
   import ucs_pkg::*;
#(
   parameter int             OP_W   = 6,
   parameter int             UPC_W  = 4,
   parameter int             TBL    = 1,
   parameter logic [OP_W-1:0] OP_ALU = 6'h00,
   parameter logic [OP_W-1:0] OP_LD  = 6'h23,
   parameter logic [OP_W-1:0] OP_ST  = 6'h2B,
   parameter logic [OP_W-1:0] OP_BR  = 6'h04,
   parameter logic [OP_W-1:0] OP_JMP = 6'h02
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] tgt
);

   generate
      if (TBL == 1) begin : g_tbl_decode
         always_comb begin
            if (opcode == OP_ALU)
               tgt = UPC_W'(UA_ALU1);
            else if (opcode == OP_LD || opcode == OP_ST)
               tgt = UPC_W'(UA_MEM1);
            else if (opcode == OP_BR)
               tgt = UPC_W'(UA_BR1);
            else if (opcode == OP_JMP)
               tgt = UPC_W'(UA_JMP1);
            else
               tgt = UPC_W'(UA_FETCH);
         end
      end else if (TBL == 2) begin : g_tbl_mem
         always_comb begin
            if (opcode == OP_LD)
               tgt = UPC_W'(UA_LD2);
            else if (opcode == OP_ST)
               tgt = UPC_W'(UA_ST2);
            else
               tgt = UPC_W'(UA_FETCH);
         end
      end else begin : g_tbl_bad
         $error("ucs_dispatch: TBL must be 1 or 2");
         assign tgt = '0;
      end
   endgenerate

endmodule

// File: rtl/ucs_store.sv
module ucs_store
   import ucs_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic [UPC_W-1:0] upc,
   output uword_t           word
);

   localparam int DEPTH = 1 << UPC_W;

   if (UPC_W < 4 || UPC_W > 8) begin : g_bad_width
      $error("ucs_store: UPC_W must lie in 4..8");
   end

   function automatic uword_t build_word(input int addr);
      uword_t w;
      w = '0;
      case (addr)
         UA_FETCH: begin
            w.alu = ALU_ADD;  w.src_a = 1'b0; w.src_b = SRCB_FOUR;
            w.mctl = MCTL_IFETCH; w.pctl = PCW_ALU; w.seq = SEQ_NEXT;
         end
         UA_DECODE: begin
            w.alu = ALU_ADD;  w.src_a = 1'b0; w.src_b = SRCB_IMM_SH;
            w.rctl = RCTL_READ; w.seq = SEQ_DISP1;
         end
         UA_MEM1: begin
            w.alu = ALU_ADD;  w.src_a = 1'b1; w.src_b = SRCB_IMM;
            w.seq = SEQ_DISP2;
         end
         UA_LD2: begin
            w.mctl = MCTL_RD_ALU; w.seq = SEQ_NEXT;
         end
         UA_LD3: begin
            w.rctl = RCTL_WR_MDR; w.seq = SEQ_FETCH;
         end
         UA_ST2: begin
            w.mctl = MCTL_WR_ALU; w.seq = SEQ_FETCH;
         end
         UA_ALU1: begin
            w.alu = ALU_FUNC; w.src_a = 1'b1; w.src_b = SRCB_REG;
            w.seq = SEQ_NEXT;
         end
         UA_ALU2: begin
            w.rctl = RCTL_WR_ALU; w.seq = SEQ_FETCH;
         end
         UA_BR1: begin
            w.alu = ALU_SUB;  w.src_a = 1'b1; w.src_b = SRCB_REG;
            w.pctl = PCW_COND; w.seq = SEQ_FETCH;
         end
         UA_JMP1: begin
            w.pctl = PCW_JUMP; w.seq = SEQ_FETCH;
         end
         default: w = '0;
      endcase
      return w;
   endfunction

   uword_t rom [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      assign rom[a] = build_word(a);
   end

   assign word = rom[upc];

endmodule

// File: rtl/ucs_decode.sv
module ucs_decode
   import ucs_pkg::*;
(
   input  uword_t     word,
   output logic       pc_wr,
   output logic       pc_wr_cond,
   output logic       addr_sel,
   output logic       mem_rd,
   output logic       mem_wr,
   output logic       ir_wr,
   output logic       reg_wr,
   output logic       reg_dst_sel,
   output logic       wb_sel,
   output logic [1:0] alu_op,
   output logic       alu_a_sel,
   output logic [1:0] alu_b_sel,
   output logic [1:0] pc_src
);

   assign alu_op    = word.alu;
   assign alu_a_sel = word.src_a;
   assign alu_b_sel = word.src_b;

   always_comb begin
      reg_wr      = 1'b0;
      reg_dst_sel = 1'b0;
      wb_sel      = 1'b0;
      case (word.rctl)
         RCTL_WR_ALU: begin reg_wr = 1'b1; reg_dst_sel = 1'b1; end
         RCTL_WR_MDR: begin reg_wr = 1'b1; wb_sel = 1'b1; end
         default: ;
      endcase
   end

   always_comb begin
      mem_rd   = 1'b0;
      mem_wr   = 1'b0;
      addr_sel = 1'b0;
      ir_wr    = 1'b0;
      case (word.mctl)
         MCTL_IFETCH: begin mem_rd = 1'b1; ir_wr = 1'b1; end
         MCTL_RD_ALU: begin mem_rd = 1'b1; addr_sel = 1'b1; end
         MCTL_WR_ALU: begin mem_wr = 1'b1; addr_sel = 1'b1; end
         default: ;
      endcase
   end

   always_comb begin
      pc_wr      = 1'b0;
      pc_wr_cond = 1'b0;
      pc_src     = 2'b00;
      case (word.pctl)
         PCW_ALU:  pc_wr = 1'b1;
         PCW_COND: begin pc_wr_cond = 1'b1; pc_src = 2'b01; end
         PCW_JUMP: begin pc_wr = 1'b1; pc_src = 2'b10; end
         default: ;
      endcase
   end

endmodule

// File: rtl/ucs_next.sv
module ucs_next
   import ucs_pkg::*;
#(
   parameter int UPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_e             seq,
   input  logic [UPC_W-1:0] tgt_a,
   input  logic [UPC_W-1:0] tgt_b,
   output logic [UPC_W-1:0] upc
);

   logic [UPC_W-1:0] upc_nx;

   always_comb begin
      case (seq)
         SEQ_NEXT:  upc_nx = upc + 1'b1;
         SEQ_DISP1: upc_nx = tgt_a;
         SEQ_DISP2: upc_nx = tgt_b;
         default:   upc_nx = UPC_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= UPC_W'(UA_FETCH);
      else        upc <= upc_nx;
   end

   assert_seq_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SEQ_NEXT) |=> (upc == UPC_W'($past(upc) + 1'b1)));

   assert_fetch_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq == SEQ_FETCH) |=> (upc == UPC_W'(UA_FETCH)));

endmodule

// File: rtl/ucode_seq_ctrl.sv
module ucode_seq_ctrl
   import ucs_pkg::*;
#(
   parameter int             OP_W   = 6,
   parameter int             UPC_W  = 4,
   parameter logic [OP_W-1:0] OP_ALU = 6'h00,
   parameter logic [OP_W-1:0] OP_LD  = 6'h23,
   parameter logic [OP_W-1:0] OP_ST  = 6'h2B,
   parameter logic [OP_W-1:0] OP_BR  = 6'h04,
   parameter logic [OP_W-1:0] OP_JMP = 6'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OP_W-1:0]  opcode,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic             addr_sel,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             ir_wr,
   output logic             reg_wr,
   output logic             reg_dst_sel,
   output logic             wb_sel,
   output logic [1:0]       alu_op,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       pc_src,
   output logic [UPC_W-1:0] upc
);

   localparam int N_TBL = 2;

   if (OP_W < 1) begin : g_bad_op
      $error("ucode_seq_ctrl: OP_W must be positive");
   end

   uword_t           word;
   logic [UPC_W-1:0] disp_tgt [N_TBL];

   ucs_store #(.UPC_W(UPC_W)) u_store (
      .upc  (upc),
      .word (word)
   );

   for (genvar g = 0; g < N_TBL; g++) begin : g_disp
      ucs_dispatch #(
         .OP_W(OP_W), .UPC_W(UPC_W), .TBL(g + 1),
         .OP_ALU(OP_ALU), .OP_LD(OP_LD), .OP_ST(OP_ST),
         .OP_BR(OP_BR), .OP_JMP(OP_JMP)
      ) u_disp (
         .opcode (opcode),
         .tgt    (disp_tgt[g])
      );
   end

   ucs_next #(.UPC_W(UPC_W)) u_next (
      .clk   (clk),
      .rst_n (rst_n),
      .seq   (word.seq),
      .tgt_a (disp_tgt[0]),
      .tgt_b (disp_tgt[1]),
      .upc   (upc)
   );

   ucs_decode u_decode (
      .word        (word),
      .pc_wr       (pc_wr),
      .pc_wr_cond  (pc_wr_cond),
      .addr_sel    (addr_sel),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .ir_wr       (ir_wr),
      .reg_wr      (reg_wr),
      .reg_dst_sel (reg_dst_sel),
      .wb_sel      (wb_sel),
      .alu_op      (alu_op),
      .alu_a_sel   (alu_a_sel),
      .alu_b_sel   (alu_b_sel),
      .pc_src      (pc_src)
   );

   assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_pcw_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_wr, pc_wr_cond}));

   assert_irload_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ir_wr |-> (mem_rd && !addr_sel && upc == UPC_W'(UA_FETCH)));

   assert_upc_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      upc <= UPC_W'(UA_LAST));

   assert_jump_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_DECODE) && opcode == OP_JMP) |=> (upc == UPC_W'(UA_JMP1)));

   assert_alu_dispatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(UA_DECODE) && opcode == OP_ALU) |=> (upc == UPC_W'(UA_ALU1)));

endmodule

// File: tb/ucode_seq_ctrl_tb.sv
`timescale 1ns/1ps
module ucode_seq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;
   logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
   logic       reg_wr, reg_dst_sel, wb_sel, alu_a_sel;
   logic [1:0] alu_op, alu_b_sel, pc_src;
   logic [3:0] upc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ucode_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
      .reg_dst_sel(reg_dst_sel), .wb_sel(wb_sel), .alu_op(alu_op),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .pc_src(pc_src),
      .upc(upc)
   );

   // bundle: pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_wr,reg_wr,reg_dst,wb,alu_op,a,b,pc_src
   function automatic logic [15:0] bundle();
      return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, reg_wr,
              reg_dst_sel, wb_sel, alu_op, alu_a_sel, alu_b_sel, pc_src};
   endfunction

   function automatic logic [15:0] mk(input bit pw, input bit pwc, input bit as,
      input bit mr, input bit mw, input bit ir, input bit rw, input bit rd,
      input bit wb, input logic [1:0] op, input bit a, input logic [1:0] b,
      input logic [1:0] ps);
      return {pw, pwc, as, mr, mw, ir, rw, rd, wb, op, a, b, ps};
   endfunction

   // expected controls per word, from R2..R10
   function automatic logic [15:0] exp_ctl(input int a);
      case (a)
         0: return mk(1,0,0,1,0,1,0,0,0,2'b00,0,2'b01,2'b00); // R2
         1: return mk(0,0,0,0,0,0,0,0,0,2'b00,0,2'b11,2'b00); // R3
         2: return mk(0,0,0,0,0,0,0,0,0,2'b00,1,2'b10,2'b00); // R4
         3: return mk(0,0,1,1,0,0,0,0,0,2'b00,0,2'b00,2'b00); // R5
         4: return mk(0,0,0,0,0,0,1,0,1,2'b00,0,2'b00,2'b00); // R5
         5: return mk(0,0,1,0,1,0,0,0,0,2'b00,0,2'b00,2'b00); // R6
         6: return mk(0,0,0,0,0,0,0,0,0,2'b10,1,2'b00,2'b00); // R7
         7: return mk(0,0,0,0,0,0,1,1,0,2'b00,0,2'b00,2'b00); // R7
         8: return mk(0,1,0,0,0,0,0,0,0,2'b01,1,2'b00,2'b01); // R8
         9: return mk(1,0,0,0,0,0,0,0,0,2'b00,0,2'b00,2'b10); // R9
         default: return '0;                                   // R10
      endcase
   endfunction

   task automatic check_upc(input int exp, input string req);
      checks++;
      if (upc !== 4'(exp)) begin
         errors++;
         $display("FAIL %s: upc actual %0d expected %0d", req, upc, exp);
      end
   endtask

   task automatic check_ctl(input int a, input string req);
      checks++;
      if (bundle() !== exp_ctl(a)) begin
         errors++;
         $display("FAIL %s: controls at word %0d actual %h expected %h",
                  req, a, bundle(), exp_ctl(a));
      end
   endtask

   // {opcode, length, path of five 4-bit addresses, first step in top nibble}
   localparam int NV = 7;
   localparam logic [28:0] VEC [NV] = '{
      {6'h00, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},  // R7 ALU op
      {6'h23, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},  // R5 load
      {6'h2B, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},  // R6 store
      {6'h04, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},  // R8 branch
      {6'h02, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},  // R9 jump
      {6'h3F, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0},  // R3 unknown
      {6'h08, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0}   // R3 unknown
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_upc(0, "R1");
      check_ctl(0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_upc(1, "R1_R11");

      // finish that pass: opcode 0x3F unknown -> back to fetch
      opcode = 6'h3F;
      @(negedge clk);
      check_upc(0, "R3");

      // table walk
      for (int i = 0; i < NV; i++) begin
         int len;
         opcode = VEC[i][28:23];
         len = int'(VEC[i][22:20]);
         for (int s = 0; s < len; s++) begin
            int a;
            a = int'(VEC[i][19 - 4*s -: 4]);
            check_upc(a, "R11");
            check_ctl(a, "R10");
            @(negedge clk);
         end
         check_upc(0, "R11");
      end

      // R4: opcode changed after decode -> second table falls to fetch
      opcode = 6'h23;
      @(negedge clk);           // at decode
      check_upc(1, "R3");
      @(negedge clk);           // at address word
      check_upc(2, "R4");
      opcode = 6'h00;
      @(negedge clk);
      check_upc(0, "R4");

      // R4: store re-routed to load by second table sample
      opcode = 6'h2B;
      repeat (2) @(negedge clk);
      check_upc(2, "R4");
      opcode = 6'h23;
      @(negedge clk);
      check_upc(3, "R4");
      check_ctl(3, "R5");
      @(negedge clk);
      check_upc(4, "R5");

      // R1: asynchronous reset in mid-load
      #1 rst_n = 1'b0;
      #1;
      check_upc(0, "R1");
      check_ctl(0, "R1");
      @(negedge clk);
      check_upc(0, "R1");
      rst_n = 1'b1;
      opcode = 6'h02;
      @(negedge clk);
      check_upc(1, "R1");
      @(negedge clk);
      check_upc(9, "R9");
      check_ctl(9, "R9");
      @(negedge clk);
      check_upc(0, "R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule